// File: doc/BRIEF.md
# Packed Integer Compare-and-Combine Stage

This stage compares two 32-bit operands lane by lane and turns each outcome into a stored boolean. The 32-bit word can be one 32-bit lane, two 16-bit lanes or four 8-bit lanes. Each compare can be signed or unsigned. A third operand, C, carries an earlier condition. Each lane of C counts as true when any of its bits is set, and it is merged with the fresh outcome by OR or by AND. This lets a chain of conditions build up without separate bitwise instructions. A plain compare uses C = 0 with OR.

A true lane is written as integer one, all ones, or floating-point one for the lane width. A false lane is always zero. In chained mode a 64-bit compare takes two issues. The first issue compares the low words unsigned, in normal mode, with the one-for-true type. The second issue compares the high words with chaining set and feeds the first result in as C. The result appears one clock after it is issued, behind a valid flag.

Top module: `pcmp_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is `out_valid` = 0 and `out_data` = 0.
- R2: `out_valid` equals the `in_valid` sampled at the previous rising edge. `out_data` holds its value when `in_valid` was low.
- R3: Unsigned compares use these condition codes: 0 equal, 1 not-equal, 2 less, 3 less-or-equal, 4 greater, 5 greater-or-equal. Codes 6 and 7 give a false compare outcome.
- R4: With `is_signed` = 1 each lane is compared as two's complement within its own width.
- R5: `lane_mode` 0 (and 3) gives one 32-bit lane, 1 gives two 16-bit lanes and 2 gives four 8-bit lanes. Lane i covers bits [i*W +: W], and lanes never affect each other.
- R6: With `comb_and` = 0 a lane is true when its compare holds or any bit of the same lane of `op_c` is set.
- R7: With `comb_and` = 1 a lane is true only when its compare holds and the same lane of `op_c` is nonzero.
- R8: `rtype` 0 and 3 write 1 into a true lane. `rtype` 1 writes all ones. A false lane is zero for every type.
- R9: `rtype` 2 writes 0x3F800000 into a true 32-bit lane and 0x3C00 into a true 16-bit lane. In 8-bit mode it always writes zero.
- R10: With `chain` = 1 the word is one 32-bit lane and `comb_and` is ignored. The result is true when the strict part of the condition holds, or when the operands are equal and `op_c` is nonzero. The strict part is greater for codes 4 and 5, less for codes 2 and 3, not-equal for code 1, and none for code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Issue strobe |
| op_a | input | 32 | Left operand |
| op_b | input | 32 | Right operand |
| op_c | input | 32 | Chained condition operand |
| cond | input | 3 | Condition code |
| lane_mode | input | 2 | Lane partition |
| is_signed | input | 1 | Two's complement compare |
| comb_and | input | 1 | 1 = AND merge, 0 = OR merge |
| chain | input | 1 | 64-bit high-word step |
| rtype | input | 2 | Result encoding |
| out_valid | output | 1 | Result valid |
| out_data | output | 32 | Packed result |

## Verification
Every result, including `out_valid`, is due at the first rising edge after the issue. It is still there at the rising edge after that, unless a new issue replaces the data. The bench changes inputs on the falling edge. It compares the outputs 1 ns after each rising edge with a behavioural model that was updated at that same edge. Idle cycles are compared too, which checks that the data holds. Two-issue 64-bit compares are run with the first result fed back as C, and the final boolean is checked against a true 64-bit compare.

// File: rtl/pcmp_pkg.sv
// Shared encodings for the packed compare stage.
package pcmp_pkg;
    typedef enum logic [2:0] {
        CND_EQ = 3'd0, CND_NE = 3'd1, CND_LT = 3'd2,
        CND_LE = 3'd3, CND_GT = 3'd4, CND_GE = 3'd5,
        CND_R6 = 3'd6, CND_R7 = 3'd7
    } cond_e;

    typedef enum logic [1:0] {
        LM_W32 = 2'd0, LM_H16 = 2'd1, LM_B8 = 2'd2, LM_ALT = 2'd3
    } lane_mode_e;

    typedef enum logic [1:0] {
        RT_ONE = 2'd0, RT_ALL = 2'd1, RT_FP = 2'd2, RT_ONE_LO = 2'd3
    } rtype_e;

    // Floating-point one for a lane width; zero where the width has none.
    function automatic logic [31:0] fp_one(input int w);
        if (w == 32)      return 32'h3F80_0000;
        else if (w == 16) return 32'h0000_3C00;
        else              return 32'h0;
    endfunction
endpackage

// File: rtl/pcmp_lane.sv
// One compare lane: compares a against b, merges with lane c.
// Assumes CHAIN=1 only for the full-width lane that serves 64-bit chaining.
module pcmp_lane
    import pcmp_pkg::*;
#(
    parameter int W     = 32,
    parameter bit CHAIN = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  cond_e        cond,
    input  logic         is_signed,
    input  logic         comb_and,
    input  logic         chain,
    output logic         hit
);
    logic eq, lt, gt, c_any, base, strict;

    // Raw ordering of the operands in the chosen signedness.
    always_comb begin
        eq = (a == b);
        if (is_signed && (a[W-1] != b[W-1])) lt = a[W-1];
        else                                 lt = (a < b);
        gt    = !lt && !eq;
        c_any = |c;
    end

    // Evaluate the full and the strict form of the condition.
    always_comb begin
        unique case (cond)
            CND_EQ:  begin base = eq;       strict = 1'b0; end
            CND_NE:  begin base = !eq;      strict = !eq;  end
            CND_LT:  begin base = lt;       strict = lt;   end
            CND_LE:  begin base = lt || eq; strict = lt;   end
            CND_GT:  begin base = gt;       strict = gt;   end
            CND_GE:  begin base = gt || eq; strict = gt;   end
            default: begin base = 1'b0;     strict = 1'b0; end
        endcase
    end

    // Merge with the chained operand.
    always_comb begin
        if (CHAIN && chain) hit = strict || (eq && c_any);
        else if (comb_and)  hit = base && c_any;
        else                hit = base || c_any;
    end
endmodule

// File: rtl/pcmp_fmt.sv
// Encodes one lane boolean as the selected result type.
// Assumes W is 8, 16 or 32; floating-point one is zero for other widths.
module pcmp_fmt
    import pcmp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         hit,
    input  rtype_e       rtype,
    output logic [W-1:0] val
);
    localparam logic [31:0] FONE32 = fp_one(W);
    localparam logic [W-1:0] FONE  = FONE32[W-1:0];

    // Pick the lane encoding; a false lane is zero.
    always_comb begin
        val = '0;
        if (hit) begin
            unique case (rtype)
                RT_ALL:  val = '1;
                RT_FP:   val = FONE;
                default: val = W'(1);
            endcase
        end
    end
endmodule

// File: rtl/pcmp_unit.sv
// Packed compare-and-combine stage with one-cycle registered output.
// Builds every lane partition in parallel and selects one; chaining
// forces the 32-bit partition.
module pcmp_unit
    import pcmp_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_PARTS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] op_c,
    input  logic [2:0]        cond,
    input  logic [1:0]        lane_mode,
    input  logic              is_signed,
    input  logic              comb_and,
    input  logic              chain,
    input  logic [1:0]        rtype,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    cond_e      cond_q;
    rtype_e     rtype_q;
    lane_mode_e mode_q;
    logic [DATA_W-1:0] sel;

    assign cond_q  = cond_e'(cond);
    assign rtype_q = rtype_e'(rtype);
    assign mode_q  = lane_mode_e'(lane_mode);

    for (genvar g = 0; g < NUM_PARTS; g++) begin : g_part
        localparam int W  = DATA_W >> g;
        localparam int NL = 1 << g;
        logic [DATA_W-1:0] vec;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            logic hit;
            pcmp_lane #(.W(W), .CHAIN(g == 0)) u_lane (
                .a(op_a[l*W +: W]), .b(op_b[l*W +: W]), .c(op_c[l*W +: W]),
                .cond(cond_q), .is_signed(is_signed), .comb_and(comb_and),
                .chain(chain), .hit(hit)
            );
            pcmp_fmt #(.W(W)) u_fmt (
                .hit(hit), .rtype(rtype_q), .val(vec[l*W +: W])
            );
        end
    end

    // Choose the active partition.
    always_comb begin
        if (chain) sel = g_part[0].vec;
        else begin
            unique case (mode_q)
                LM_H16:  sel = g_part[1].vec;
                LM_B8:   sel = g_part[2].vec;
                default: sel = g_part[0].vec;
            endcase
        end
    end

    // Register result and valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= sel;
        end
    end
endmodule

// File: rtl/pcmp_unit_chk.sv
// Temporal checks on pcmp_unit, bound to every instance.
module pcmp_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] op_a,
    input logic [31:0] op_b,
    input logic [31:0] op_c,
    input logic [2:0]  cond,
    input logic [1:0]  lane_mode,
    input logic        comb_and,
    input logic        chain,
    input logic [1:0]  rtype,
    input logic        out_valid,
    input logic [31:0] out_data
);
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
    p_or_c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !chain && !comb_and && lane_mode == 2'd0 && op_c != 0 && rtype == 2'd0)
        |=> out_data == 32'd1);
    p_and_c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !chain && comb_and && lane_mode == 2'd0 && op_c == 0) |=> out_data == 32'd0);
    p_all_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !chain && lane_mode == 2'd0 && rtype == 2'd1)
        |=> (out_data == 32'd0 || out_data == 32'hFFFF_FFFF));
    p_fp_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !chain && lane_mode == 2'd2 && rtype == 2'd2) |=> out_data == 32'd0);
    p_chain_eq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chain && op_a == op_b && op_c == 0 && cond == 3'd4) |=> out_data == 32'd0);
endmodule

bind pcmp_unit pcmp_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .op_c(op_c), .cond(cond), .lane_mode(lane_mode), .comb_and(comb_and),
    .chain(chain), .rtype(rtype), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/pcmp_unit_tb.sv
`timescale 1ns/1ps
module pcmp_unit_tb;
    logic clk = 0, rst_n = 0, in_valid = 0;
    logic [31:0] op_a = 0, op_b = 0, op_c = 0;
    logic [2:0] cond = 0;
    logic [1:0] lane_mode = 0, rtype = 0;
    logic is_signed = 0, comb_and = 0, chain = 0;
    logic out_valid;
    logic [31:0] out_data;
    int n_run = 0, n_fail = 0;
    logic exp_valid = 0;
    logic [31:0] exp_data = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pcmp_unit u_dut (.*);

    // Behavioural reference for one issue.
    function automatic logic [31:0] model(input logic [31:0] a, b, c, input int cd, md,
                                          input bit sg, ca, ch, input int rt);
        int w = ch ? 32 : (md == 1 ? 16 : (md == 2 ? 8 : 32));
        longint mask = (longint'(1) << w) - 1;
        logic [31:0] r = 0;
        for (int i = 0; i < 32 / w; i++) begin
            longint av = (longint'(a) >> (i*w)) & mask;
            longint bv = (longint'(b) >> (i*w)) & mask;
            longint cv = (longint'(c) >> (i*w)) & mask;
            bit t, s, h;
            longint lv = 0;
            if (sg && av[w-1]) av = av - (longint'(1) << w);
            if (sg && bv[w-1]) bv = bv - (longint'(1) << w);
            case (cd)
                0: begin t = av == bv; s = 0; end
                1: begin t = av != bv; s = t; end
                2: begin t = av < bv;  s = t; end
                3: begin t = av <= bv; s = av < bv; end
                4: begin t = av > bv;  s = t; end
                5: begin t = av >= bv; s = av > bv; end
                default: begin t = 0; s = 0; end
            endcase
            if (ch) h = s || (av == bv && cv != 0);
            else if (ca) h = t && cv != 0;
            else h = t || cv != 0;
            if (h) lv = (rt == 1) ? mask : (rt == 2 ? (w == 32 ? 64'h3F800000 : (w == 16 ? 64'h3C00 : 0)) : 1);
            r = r | 32'(lv << (i*w));
        end
        return r;
    endfunction

    task automatic check(input string req);
        n_run++;
        if (out_valid !== exp_valid || out_data !== exp_data) begin
            n_fail++;
            $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
                     req, out_valid, out_data, exp_valid, exp_data);
        end
    endtask

    // One clock: drive at falling edge, update model, compare after rising edge.
    task automatic step(input bit v, input logic [31:0] a, b, c, input int cd, md,
                        input bit sg, ca, ch, input int rt, input string req);
        @(negedge clk);
        in_valid = v; op_a = a; op_b = b; op_c = c; cond = cd[2:0]; lane_mode = md[1:0];
        is_signed = sg; comb_and = ca; chain = ch; rtype = rt[1:0];
        @(posedge clk);
        exp_valid = v;
        if (v) exp_data = model(a, b, c, cd, md, sg, ca, ch, rt);
        #1 check(req);
    endtask

    task automatic issue(input logic [31:0] a, b, c, input int cd, md,
                         input bit sg, ca, ch, input int rt, input string req);
        step(1, a, b, c, cd, md, sg, ca, ch, rt, req);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lo_r, hi_r;
        repeat (3) @(posedge clk);
        #1 check("R1");
        @(negedge clk); rst_n = 1;
        // R3 conditions, unsigned, 32-bit
        for (int cd = 0; cd < 8; cd++) begin
            issue(32'h10, 32'h20, 0, cd, 0, 0, 0, 0, 0, "R3 a<b");
            issue(32'h20, 32'h20, 0, cd, 0, 0, 0, 0, 0, "R3 a==b");
            issue(32'hF000_0000, 32'h1, 0, cd, 0, 0, 0, 0, 1, "R3 a>b");
        end
        // R4 signed versus unsigned
        issue(32'hFFFF_FFFF, 32'h1, 0, 2, 0, 1, 0, 0, 1, "R4 signed -1<1");
        issue(32'hFFFF_FFFF, 32'h1, 0, 2, 0, 0, 0, 0, 1, "R4 unsigned");
        issue(32'h80FF_7F01, 32'h7F01_80FF, 0, 4, 2, 1, 0, 0, 1, "R4 bytes signed");
        issue(32'h8000_7FFF, 32'h7FFF_8000, 0, 2, 1, 1, 0, 0, 1, "R4 halves signed");
        // R5 lane independence
        issue(32'h0102_0304, 32'h0102_0504, 0, 0, 2, 0, 0, 0, 1, "R5 bytes");
        issue(32'h1234_5678, 32'h1234_5679, 0, 1, 1, 0, 0, 0, 0, "R5 halves");
        issue(32'h1234_5678, 32'h1234_5679, 0, 1, 3, 0, 0, 0, 0, "R5 mode3");
        // R6 OR merge, R7 AND merge
        issue(5, 5, 32'h0000_0100, 1, 0, 0, 0, 0, 0, "R6 c sets");
        issue(5, 5, 32'h0001_0000, 1, 1, 0, 0, 0, 1, "R6 c upper half");
        issue(5, 6, 0, 2, 0, 0, 1, 0, 0, "R7 c zero");
        issue(32'h0505_0505, 32'h0606_0606, 32'h0080_0001, 2, 2, 0, 1, 0, 1, "R7 per byte");
        // R8 result types
        issue(1, 2, 0, 2, 1, 0, 0, 0, 3, "R8 one");
        issue(1, 2, 0, 2, 1, 0, 0, 0, 1, "R8 all");
        issue(2, 1, 0, 2, 0, 0, 0, 0, 1, "R8 false zero");
        // R9 floating one
        issue(1, 2, 0, 2, 0, 0, 0, 0, 2, "R9 f32");
        issue(32'h0001_0001, 32'h0002_0000, 0, 2, 1, 0, 0, 0, 2, "R9 f16");
        issue(0, 32'hFFFF_FFFF, 0, 2, 2, 0, 0, 0, 2, "R9 byte zero");
        // R2 hold and valid tracking
        step(0, 32'hDEAD, 0, 0, 1, 0, 0, 0, 0, 1, "R2 idle hold");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R2 idle hold");
        // R10 chained 64-bit compares
        for (int k = 0; k < 40; k++) begin
            logic [63:0] x, y;
            int cd;
            bit sg;
            bit truth;
            x = {$urandom, $urandom}; y = {$urandom, $urandom};
            if (k % 4 == 0) y[63:32] = x[63:32];
            if (k % 8 == 0) y = x;
            cd = k % 6; sg = k[0];
            issue(x[31:0], y[31:0], 0, cd, 0, 0, 0, 0, 3, "R10 low word");
            lo_r = out_data;
            issue(x[63:32], y[63:32], lo_r, cd, 2, sg, 1, 1, 1, "R10 high word");
            hi_r = out_data;
            case (cd)
                0: truth = x == y;
                1: truth = x != y;
                2: truth = sg ? $signed(x) < $signed(y) : x < y;
                3: truth = sg ? $signed(x) <= $signed(y) : x <= y;
                4: truth = sg ? $signed(x) > $signed(y) : x > y;
                default: truth = sg ? $signed(x) >= $signed(y) : x >= y;
            endcase
            n_run++;
            if (hi_r !== (truth ? 32'hFFFF_FFFF : 32'h0)) begin
                n_fail++;
                $display("FAIL R10 64-bit: actual=%h expected=%h", hi_r, truth ? 32'hFFFF_FFFF : 32'h0);
            end
        end
        // Mixed random traffic across all modes
        for (int k = 0; k < 400; k++)
            step($urandom_range(0, 3) != 0, $urandom, ($urandom % 3 == 0) ? op_a : $urandom,
                 ($urandom % 2) ? 0 : $urandom, $urandom_range(0, 7), $urandom_range(0, 3),
                 $urandom % 2, $urandom % 2, ($urandom % 5) == 0, $urandom_range(0, 3), "R5 mixed");
        @(negedge clk); rst_n = 0;
        @(posedge clk); exp_valid = 0; exp_data = 0;
        #1 check("R1 reset again");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule